// File: doc/BRIEF.md
# DMA Burst and Address-Wrap Sequencer

This block is the per-channel sequencing core of a small DMA engine. A start pulse captures a configuration: source and destination base addresses, a total transfer count, a transfer width, a power-of-two burst code, independent wrap enables for the read side and the write side, and a burst-per-trigger mode bit. Configurations that cannot be honoured raise an error flag and leave the block idle. After a valid start the block waits for a trigger. It then issues one read/write address pair per transfer over a request/acknowledge handshake and counts down the transfers that remain.

The burst code sets how long a burst is. It also sets the size of the address window used when wrapping is enabled. A wrapped address goes back to its base value at every burst boundary, so each burst touches the same address range. In burst-per-trigger mode, each trigger releases one burst. One trigger that arrives during a burst is remembered and serviced as soon as that burst ends. Without that mode, one trigger runs the whole count with no pause. A one-cycle done pulse marks the end of the transfer.

Top module: `dma_burst_seq`

## Requirements
- R1: The 4-bit burst code N gives a burst length of 2^N transfers. Codes 0 to 10 are legal, so a burst is 1 to 1024 transfers long.
- R2: In the cycle after a start, `cfg_err` is 1 if any of these holds: the burst code is above 10, `xfer_width` is 3, the count is 0, the count is above 1024, or the count is not a whole multiple of 2^N. In that case `busy` stays 0, no request is issued, and triggers have no effect. A valid start clears `cfg_err`.
- R3: `xfer_width` codes 0, 1 and 2 mean 1, 2 and 4 bytes. Each acknowledged transfer advances a non-wrapped address by that many bytes. While `req` is high and `ack` is low, both addresses hold their values.
- R4: With `src_wrap` = 1, `rd_addr` returns to `src_base` after the last transfer of each burst, so every burst reads the same range.
- R5: With `dst_wrap` = 1, `wr_addr` behaves the same way with respect to `dst_base`. This does not depend on `src_wrap`.
- R6: With `trig_burst` = 1, each trigger starts exactly one burst of 2^N transfers. After that burst, the block waits with `busy` = 1 and `req` = 0 until the next trigger.
- R7: With `trig_burst` = 0, one trigger runs the whole count back to back. Bursts still set the wrap window.
- R8: In burst-per-trigger mode, a trigger seen during a burst is held as one pending request. This includes a trigger in the cycle of the burst's final acknowledge. The next burst then starts with no new trigger. Further triggers in that window are dropped.
- R9: `done` is high for exactly one cycle, in the cycle after the last acknowledge. In that same cycle `busy` falls. Triggers have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture configuration and arm (only acted on while idle) |
| src_base | input | AW | Start source address |
| dst_base | input | AW | Start destination address |
| xfer_count | input | CW | Total number of transfers, 1 to 1024 |
| xfer_width | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: illegal |
| burst_code | input | 4 | Burst length 2^code, legal 0 to 10 |
| src_wrap | input | 1 | Wrap the read address at each burst |
| dst_wrap | input | 1 | Wrap the write address at each burst |
| trig_burst | input | 1 | One burst per trigger when high |
| trig | input | 1 | Transfer trigger pulse |
| req | output | 1 | Transfer request |
| ack | input | 1 | Transfer acknowledge |
| rd_addr | output | AW | Read address of the current transfer |
| wr_addr | output | AW | Write address of the current transfer |
| busy | output | 1 | Armed or transferring |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Rejected configuration |

## Verification
Two events can fall on the same clock edge: the acknowledge that ends a burst and a new trigger. The bench provokes this by raising the trigger only in the cycle where it also drives the burst's final acknowledge. It judges the result by whether the next burst's request appears in the very next cycle with no further trigger, and whether the block then waits before the burst after that. A second case raises two triggers in the middle of a burst. It shows that only one burst is released without a fresh trigger. Both cases run under a stalling acknowledge pattern, with the expected addresses computed from the transfer index.

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
  parameter int AW      = 32,
  parameter int CW      = 11,
  parameter int MAXCODE = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] xfer_count,
  input  logic [1:0]    xfer_width,
  input  logic [3:0]    burst_code,
  input  logic          src_wrap,
  input  logic          dst_wrap,
  input  logic          trig_burst,
  input  logic          trig,
  output logic          req,
  input  logic          ack,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic          busy,
  output logic          done,
  output logic          cfg_err
);

  localparam logic [CW-1:0] MAXCNT = CW'(1) << MAXCODE;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} state_t;

  state_t        state;
  logic [CW-1:0] rem, bcnt, blen_q;
  logic [AW-1:0] sbase_q, dbase_q;
  logic [1:0]    width_q;
  logic          swrap_q, dwrap_q, tmode_q, pend;

  logic [CW-1:0] blen_in;
  logic          bad_cfg, bend, last, xfer;
  logic [AW-1:0] step;

  assign blen_in = CW'(1) << burst_code;
  assign bad_cfg = (burst_code > 4'(MAXCODE)) || (xfer_width == 2'd3) ||
                   (xfer_count == '0) || (xfer_count > MAXCNT) ||
                   ((xfer_count & (blen_in - CW'(1))) != '0);

  assign req  = (state == S_RUN);
  assign busy = (state != S_IDLE);
  assign xfer = req && ack;
  assign bend = (bcnt == blen_q - CW'(1));
  assign last = (rem == CW'(1));
  assign step = AW'(1) << width_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rem     <= '0;
      bcnt    <= '0;
      blen_q  <= CW'(1);
      sbase_q <= '0;
      dbase_q <= '0;
      rd_addr <= '0;
      wr_addr <= '0;
      width_q <= '0;
      swrap_q <= 1'b0;
      dwrap_q <= 1'b0;
      tmode_q <= 1'b0;
      pend    <= 1'b0;
      done    <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cfg_err <= bad_cfg;
          if (!bad_cfg) begin
            state   <= S_WAIT;
            rem     <= xfer_count;
            bcnt    <= '0;
            blen_q  <= blen_in;
            sbase_q <= src_base;
            dbase_q <= dst_base;
            rd_addr <= src_base;
            wr_addr <= dst_base;
            width_q <= xfer_width;
            swrap_q <= src_wrap;
            dwrap_q <= dst_wrap;
            tmode_q <= trig_burst;
            pend    <= 1'b0;
          end
        end
        S_WAIT: if (trig) state <= S_RUN;
        S_RUN: begin
          if (ack) begin
            rem     <= rem - CW'(1);
            bcnt    <= bend ? '0 : bcnt + CW'(1);
            rd_addr <= (bend && swrap_q) ? sbase_q : rd_addr + step;
            wr_addr <= (bend && dwrap_q) ? dbase_q : wr_addr + step;
            if (last) begin
              state <= S_IDLE;
              done  <= 1'b1;
              pend  <= 1'b0;
            end else if (bend && tmode_q) begin
              pend <= 1'b0;
              if (!(pend || trig)) state <= S_WAIT;
            end else if (trig && tmode_q) begin
              pend <= 1'b1;
            end
          end else if (trig && tmode_q) begin
            pend <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(rd_addr) && $stable(wr_addr)));

  assert_burst_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < blen_q));

  assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  assert_run_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !(xfer && bend)) |=> req);

  assert_wrap_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && bend && swrap_q && !last) |=> (rd_addr == sbase_q));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/tb_dma_burst_seq.sv
module tb_dma_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, src_wrap = 1'b0, dst_wrap = 1'b0, trig_burst = 1'b0;
  logic        trig = 1'b0, ack = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [10:0] xfer_count = '0;
  logic [1:0]  xfer_width = '0;
  logic [3:0]  burst_code = '0;
  logic        req, busy, done, cfg_err;
  logic [31:0] rd_addr, wr_addr;

  int tests = 0, fails = 0, cyc = 0;

  dma_burst_seq dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input int code, input int cnt, input int w, input bit sw,
                          input bit dw, input bit tm, input logic [31:0] sb, input logic [31:0] db);
    burst_code = 4'(code); xfer_count = 11'(cnt); xfer_width = 2'(w);
    src_wrap = sw; dst_wrap = dw; trig_burst = tm; src_base = sb; dst_base = db;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  // pend: 0 none, 1 two triggers mid first burst, 2 trigger on first burst's final ack
  task automatic run(input int code, input int cnt, input int w, input bit sw,
                     input bit dw, input bit tm, input int pend);
    int blen, bytes, i, nb;
    logic [31:0] sb, db, er, ew;
    blen = 1 << code; bytes = 1 << w; i = 0;
    sb = 32'h1000_0000 + 32'(code * 256 + w * 16);
    db = 32'h2000_0000 + 32'(cnt * 8);
    do_start(code, cnt, w, sw, dw, tm, sb, db);
    chk(!cfg_err && busy && !req, "R2 valid start arms", {cfg_err, busy, req}, 3'b010);
    nb = tm ? cnt / blen : 1;
    for (int b = 0; b < nb; b++) begin
      int n;
      n = tm ? blen : cnt;
      if (!(b == 1 && pend != 0)) pulse_trig();
      for (int j = 0; j < n;) begin
        bit a;
        er = sb + 32'((sw ? (i % blen) : i) * bytes);
        ew = db + 32'((dw ? (i % blen) : i) * bytes);
        chk(req && rd_addr == er && wr_addr == ew, "R1/R3/R4/R5/R7 rd addr", rd_addr, er);
        a = (cyc % 5) != 2; cyc++;
        ack = a;
        trig = (pend == 1 && b == 0 && (j == 1 || j == 2)) ||
               (pend == 2 && b == 0 && a && j == n - 1);
        @(negedge clk);
        ack = 1'b0; trig = 1'b0;
        if (a) begin j++; i++; end
      end
      if (i == cnt) begin
        chk(done && !busy && !req, "R9 done with final ack", {done, busy, req}, 3'b100);
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
        pulse_trig();
        @(negedge clk);
        chk(!busy && !req, "R9 trigger after done ignored", {busy, req}, 2'b00);
      end else if (!(b == 0 && pend != 0)) begin
        chk(busy && !req, "R6 waits after burst", {busy, req}, 2'b10);
        @(negedge clk);
        chk(busy && !req, "R6 R8 still waiting", {busy, req}, 2'b10);
      end else begin
        chk(req, "R8 pending trigger continues", req, 1);
      end
    end
  endtask

  task automatic bad(input int code, input int cnt, input int w, input string tag);
    do_start(code, cnt, w, 1'b0, 1'b0, 1'b1, 32'h40, 32'h80);
    chk(cfg_err && !busy, tag, {cfg_err, busy}, 2'b10);
    pulse_trig();
    @(negedge clk);
    chk(!busy && !req, "R2 trigger ignored after error", {busy, req}, 2'b00);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(!req && !busy && !done && !cfg_err, "reset state", {req, busy, done, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse_trig();
    chk(!busy && !req, "R9 trigger while idle ignored", {busy, req}, 0);

    for (int c = 0; c <= 4; c++)
      for (int w = 0; w <= 2; w++)
        for (int wr = 0; wr < 4; wr++)
          for (int tm = 0; tm < 2; tm++)
            run(c, (1 << c) * (1 + (c + w) % 3), w, wr[0], wr[1], tm[0], 0);

    run(2, 12, 2, 1'b1, 1'b0, 1'b1, 1); // R8 two mid-burst triggers
    run(2, 12, 1, 1'b0, 1'b1, 1'b1, 2); // R8 trigger on final ack
    run(0, 3, 0, 1'b1, 1'b1, 1'b1, 2);  // R8 single-transfer bursts
    run(10, 1024, 2, 1'b0, 1'b1, 1'b0, 0); // R1 R7 largest burst
    run(10, 1024, 0, 1'b1, 1'b0, 1'b1, 0); // R1 R6 one triggered burst

    bad(11, 16, 0, "R2 code 11 rejected");
    bad(15, 16, 0, "R2 code 15 rejected");
    bad(0, 4, 3, "R2 width 3 rejected");
    bad(0, 0, 0, "R2 zero count rejected");
    bad(0, 1025, 0, "R2 count above 1024 rejected");
    bad(2, 6, 0, "R2 count not multiple rejected");
    run(1, 4, 0, 1'b0, 1'b0, 1'b0, 0);   // R2 valid start clears error

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule